// File: doc/BRIEF.md
# Receive-Line Status Flag Register

This block is an eight-bit status register that sits beside a serial receiver and transmitter. It watches the receive line and raises three sticky flags. The first marks an active edge on the receive input, and a polarity select chooses whether that edge is falling or rising. The second marks a bit error, where the level sampled on the receive line differs from the bit being transmitted. The third marks a break that an external detector has reported. When a new bit error occurs, the register also keeps the receive level that was sampled at that moment.

Software reaches the register over a plain single-register bus, and only while an alternate-map select is high. A flag is cleared by writing 1 to its bit. The bit-error flag and the break flag each have an interrupt enable, and together they drive one registered interrupt request. This block does not generate the baud rate, shift data or time breaks. It only consumes strobes from the logic that does.

Top module: `rxline_status`

## Requirements
- R1: The read word holds the edge flag in bit 7, the captured error level in bit 2, the bit-error flag in bit 1 and the break flag in bit 0. Bits 6 to 3 always read 0, and every bit is 0 after reset.
- R2: The receive pin passes through a two-stage synchronizer whose stages reset to high. The edge flag sets once per synchronized transition: on a falling transition when `rx_pol` is 0, and on a rising transition when `rx_pol` is 1.
- R3: With the alternate map selected, writing 1 to bit 7, 1 or 0 clears that flag, and writing 0 leaves it unchanged. A set event in the same cycle as a clear of the same flag leaves the flag set.
- R4: The bit-error flag sets in a cycle where `berr_en` and `bit_smp` are both 1 and the synchronized receive level differs from `tx_bit`. If `berr_en` is 0, no bit error is recorded.
- R5: Bit 2 loads the synchronized receive level only in the cycle the bit-error flag goes from 0 to 1. A 0 means low was seen where high was sent, and a 1 means the reverse. It holds that value through later errors and clears until the next new error.
- R6: The break flag sets on a `brk_det` pulse only while `brk_en` is 1.
- R7: While `alt_sel` is 0, `rd_data` reads 0x00 and writes change no flag.
- R8: `irq` is the registered OR of (bit-error flag AND `berr_ie`) and (break flag AND `brk_ie`). The edge flag never drives it.
- R9: `rd_data` is registered, so it shows the register contents as they stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_pin | input | 1 | Asynchronous receive line |
| rx_pol | input | 1 | Active edge select: 0 falling, 1 rising |
| tx_bit | input | 1 | Bit currently being transmitted |
| bit_smp | input | 1 | Strobe to compare the receive level with `tx_bit` |
| berr_en | input | 1 | Bit-error detection enable |
| brk_en | input | 1 | Break detection enable |
| brk_det | input | 1 | Break-received pulse from the break timer |
| berr_ie | input | 1 | Bit-error interrupt enable |
| brk_ie | input | 1 | Break interrupt enable |
| alt_sel | input | 1 | Alternate-map select that gates reads and writes |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; a 1 clears the matching flag |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
Results arrive at different latencies:

- **Strobes and writes:** a strobe or write sampled at clock edge t changes the flag at t. The new value shows on `rd_data` and `irq` after edge t+1.
- **Receive-pin changes:** a change on the receive pin first seen at edge k sets the edge flag at k+2, because it must cross both synchronizer stages. It reaches `rd_data` after edge k+3.

The bench keeps a behavioural model that advances on the same edges. It compares both outputs on every falling clock edge, so an error of even one cycle is caught. The directed checks each wait five edges after their stimulus before they read the settled value.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;

  localparam int REG_W     = 8;
  localparam int NUM_FLAGS = 3;

  // Field positions in the read word (software decodes these)
  localparam int BIT_EDGE = 7;
  localparam int BIT_BVAL = 2;
  localparam int BIT_BERR = 1;
  localparam int BIT_BRK  = 0;

  typedef enum int {
    FLG_BRK  = 0,
    FLG_BERR = 1,
    FLG_EDGE = 2
  } flag_id_e;

  function automatic int flag_pos(int idx);
    case (idx)
      FLG_BRK:  return BIT_BRK;
      FLG_BERR: return BIT_BERR;
      default:  return BIT_EDGE;
    endcase
  endfunction

endpackage

// File: rtl/rxstat_sync_edge.sv
module rxstat_sync_edge #(
  parameter int   STAGES   = 2,
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_pin,
  input  logic pol,
  output logic rx_sync,
  output logic edge_act
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= {STAGES{IDLE_LVL}};
      prev_q  <= IDLE_LVL;
    end else begin
      chain_q[0] <= rx_pin;
      for (int i = 1; i < STAGES; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
      prev_q <= chain_q[STAGES-1];
    end
  end

  assign rx_sync  = chain_q[STAGES-1];
  assign edge_act = pol ? (rx_sync & ~prev_q) : (~rx_sync & prev_q);

  // One synchronized transition gives exactly one active cycle
  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    edge_act |=> !edge_act); // R2

endmodule

// File: rtl/rxstat_sticky.sv
module rxstat_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= set_i | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;

  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o); // R3
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_o); // R3
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> (flag_o == $past(flag_o))); // R3

endmodule

// File: rtl/rxstat_berr_chk.sv
module rxstat_berr_chk (
  input  logic clk,
  input  logic rst,
  input  logic det_en,
  input  logic sample_stb,
  input  logic tx_bit,
  input  logic rx_sync,
  input  logic flag_q,
  output logic mism_o,
  output logic bval_o
);

  logic bval_q;

  assign mism_o = det_en & sample_stb & (rx_sync ^ tx_bit);

  always_ff @(posedge clk) begin
    if (rst)                  bval_q <= 1'b0;
    else if (mism_o & ~flag_q) bval_q <= rx_sync;
  end

  assign bval_o = bval_q;

  AST_BVAL_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (mism_o && !flag_q) |=> (bval_o == $past(rx_sync))); // R5
  AST_BVAL_HOLD: assert property (@(posedge clk) disable iff (rst)
    flag_q |=> $stable(bval_o)); // R5

endmodule

// File: rtl/rxline_status.sv
module rxline_status
  import rxstat_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter logic RX_IDLE     = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_pin,
  input  logic             rx_pol,
  input  logic             tx_bit,
  input  logic             bit_smp,
  input  logic             berr_en,
  input  logic             brk_en,
  input  logic             brk_det,
  input  logic             berr_ie,
  input  logic             brk_ie,
  input  logic             alt_sel,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             irq
);

  logic                 rx_sync;
  logic                 edge_act;
  logic                 mism;
  logic                 bval;
  logic                 wr_hit;
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] flag_vec;
  logic [REG_W-1:0]     status;
  logic [REG_W-1:0]     rd_q;
  logic                 irq_q;
  logic                 unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[6:3], wr_data[BIT_BVAL]};

  rxstat_sync_edge #(
    .STAGES   (SYNC_STAGES),
    .IDLE_LVL (RX_IDLE)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .rx_pin   (rx_pin),
    .pol      (rx_pol),
    .rx_sync  (rx_sync),
    .edge_act (edge_act)
  );

  rxstat_berr_chk u_berr (
    .clk        (clk),
    .rst        (rst),
    .det_en     (berr_en),
    .sample_stb (bit_smp),
    .tx_bit     (tx_bit),
    .rx_sync    (rx_sync),
    .flag_q     (flag_vec[FLG_BERR]),
    .mism_o     (mism),
    .bval_o     (bval)
  );

  assign wr_hit            = wr_en & alt_sel;
  assign set_vec[FLG_BRK]  = brk_en & brk_det;
  assign set_vec[FLG_BERR] = mism;
  assign set_vec[FLG_EDGE] = edge_act;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    rxstat_sticky u_flag (
      .clk    (clk),
      .rst    (rst),
      .set_i  (set_vec[g]),
      .clr_i  (wr_hit & wr_data[flag_pos(g)]),
      .flag_o (flag_vec[g])
    );
  end

  always_comb begin
    status           = '0;
    status[BIT_EDGE] = flag_vec[FLG_EDGE];
    status[BIT_BVAL] = bval;
    status[BIT_BERR] = flag_vec[FLG_BERR];
    status[BIT_BRK]  = flag_vec[FLG_BRK];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      rd_q  <= alt_sel ? status : '0;
      irq_q <= (flag_vec[FLG_BERR] & berr_ie) | (flag_vec[FLG_BRK] & brk_ie);
    end
  end

  assign rd_data = rd_q;
  assign irq     = irq_q;

  AST_RD_GATED: assert property (@(posedge clk) disable iff (rst)
    !alt_sel |=> (rd_data == '0)); // R7
  AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (!alt_sel && flag_vec[FLG_EDGE]) |=> flag_vec[FLG_EDGE]); // R7
  AST_BRK_GATED: assert property (@(posedge clk) disable iff (rst)
    (!brk_en && !flag_vec[FLG_BRK]) |=> !flag_vec[FLG_BRK]); // R6
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    ((flag_vec[FLG_BERR] && berr_ie) || (flag_vec[FLG_BRK] && brk_ie)) |=> irq); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!(flag_vec[FLG_BERR] && berr_ie) && !(flag_vec[FLG_BRK] && brk_ie)) |=> !irq); // R8

endmodule

// File: tb/test_rxline_status.sv
module test_rxline_status;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_pin = 1'b1, rx_pol = 1'b0, tx_bit = 1'b0, bit_smp = 1'b0;
  logic       berr_en = 1'b0, brk_en = 1'b0, brk_det = 1'b0;
  logic       berr_ie = 1'b0, brk_ie = 1'b0;
  logic       alt_sel = 1'b1, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk; // 125 MHz

  rxline_status i_rxline_status (
    .clk(clk), .rst(rst), .rx_pin(rx_pin), .rx_pol(rx_pol), .tx_bit(tx_bit),
    .bit_smp(bit_smp), .berr_en(berr_en), .brk_en(brk_en), .brk_det(brk_det),
    .berr_ie(berr_ie), .brk_ie(brk_ie), .alt_sel(alt_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  // Behavioural reference model, advanced on every rising edge
  bit       ms1 = 1, ms2 = 1, mprev = 1;
  bit       mef, mbf, mbv, mkf, mirq;
  bit [7:0] mrd;

  always @(posedge clk) begin
    bit [7:0] clrm;
    bit       ed, mm, bk;
    if (rst) begin
      ms1 = 1; ms2 = 1; mprev = 1;
      mef = 0; mbf = 0; mbv = 0; mkf = 0; mrd = 0; mirq = 0;
    end else begin
      clrm = (wr_en && alt_sel) ? wr_data : 8'h00;
      ed   = rx_pol ? (ms2 && !mprev) : (!ms2 && mprev);
      mm   = berr_en && bit_smp && (ms2 != tx_bit);
      bk   = brk_en && brk_det;
      mrd  = alt_sel ? {mef, 4'b0000, mbv, mbf, mkf} : 8'h00;  // R9: old state
      mirq = (mbf && berr_ie) || (mkf && brk_ie);
      if (mm && !mbf) mbv = ms2;
      mef = ed || (mef && !clrm[7]);
      mbf = mm || (mbf && !clrm[1]);
      mkf = bk || (mkf && !clrm[0]);
      mprev = ms2; ms2 = ms1; ms1 = rx_pin;
    end
  end

  function automatic string tag_of(int b);
    case (b)
      7: return "R2";
      2: return "R5";
      1: return "R4";
      0: return "R6";
      default: return "R1";
    endcase
  endfunction

  // Per-cycle comparison against the model (R9 timing)
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (rd_data !== mrd) begin
        errors++;
        for (int b = 0; b < 8; b++)
          if (rd_data[b] !== mrd[b])
            $display("FAIL %s/R9 rd_data bit %0d: actual %h expected %h", tag_of(b), b, rd_data, mrd);
      end
      checks++;
      if (irq !== mirq) begin
        errors++;
        $display("FAIL R8 irq: actual %b expected %b", irq, mirq);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input logic [7:0] exp_rd, input logic exp_irq, input string req);
    repeat (5) @(posedge clk);
    @(negedge clk);
    checks++;
    if (rd_data !== exp_rd || irq !== exp_irq) begin
      errors++;
      $display("FAIL %s: actual rd=%h irq=%b expected rd=%h irq=%b", req, rd_data, irq, exp_rd, exp_irq);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    tick(); wr_en = 1'b1; wr_data = d;
    tick(); wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic smp(input logic t);
    tick(); tx_bit = t; bit_smp = 1'b1;
    tick(); bit_smp = 1'b0;
  endtask

  task automatic brk_pulse();
    tick(); brk_det = 1'b1;
    tick(); brk_det = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk(8'h00, 1'b0, "R1 reset state");

    tick(); rx_pin = 1'b0;                 chk(8'h80, 1'b0, "R2 falling edge pol0");
    wr(8'h00);                             chk(8'h80, 1'b0, "R3 write 0 keeps flag");
    wr(8'h80);                             chk(8'h00, 1'b0, "R3 write 1 clears");
    tick(); rx_pin = 1'b1;                 chk(8'h00, 1'b0, "R2 rising ignored pol0");
    tick(); rx_pol = 1'b1; rx_pin = 1'b0;  chk(8'h00, 1'b0, "R2 falling ignored pol1");
    tick(); rx_pin = 1'b1;                 chk(8'h80, 1'b0, "R2 rising edge pol1");
    wr(8'h80);                             chk(8'h00, 1'b0, "R3 clear edge flag");

    tick(); berr_en = 1'b1; berr_ie = 1'b1;
    smp(1'b1);                             chk(8'h00, 1'b0, "R4 match no error");
    tick(); rx_pin = 1'b0;                 chk(8'h00, 1'b0, "R2 falling ignored pol1");
    smp(1'b1);                             chk(8'h02, 1'b1, "R4 R5 R8 low seen high sent");
    tick(); rx_pol = 1'b0; rx_pin = 1'b1;  chk(8'h02, 1'b1, "R2 rising ignored pol0");
    smp(1'b0);                             chk(8'h02, 1'b1, "R5 value holds on later error");
    wr(8'h02);                             chk(8'h00, 1'b0, "R8 irq drops on clear");
    smp(1'b0);                             chk(8'h06, 1'b1, "R5 high seen low sent");
    wr(8'h02);                             chk(8'h04, 1'b0, "R5 value kept after clear");
    tick(); berr_en = 1'b0; berr_ie = 1'b0;
    smp(1'b0);                             chk(8'h04, 1'b0, "R4 disabled detection");

    brk_pulse();                           chk(8'h04, 1'b0, "R6 break ignored when disabled");
    tick(); brk_en = 1'b1;
    brk_pulse();                           chk(8'h05, 1'b0, "R6 R8 break sets, irq masked");
    tick(); brk_ie = 1'b1;                 chk(8'h05, 1'b1, "R8 break irq enabled");

    tick(); brk_det = 1'b1; wr_en = 1'b1; wr_data = 8'h01;
    tick(); brk_det = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    chk(8'h05, 1'b1, "R3 set wins over clear");

    tick(); alt_sel = 1'b0;                chk(8'h00, 1'b1, "R7 read gated");
    wr(8'h01);                             chk(8'h00, 1'b1, "R7 write gated");
    tick(); alt_sel = 1'b1;                chk(8'h05, 1'b1, "R7 flag survived gated write");
    wr(8'h01);                             chk(8'h04, 1'b0, "R3 break cleared");

    tick(); rx_pin = 1'b0;
    tick(); rx_pin = 1'b1;                 chk(8'h84, 1'b0, "R2 glitch sets once");
    wr(8'h80);                             chk(8'h04, 1'b0, "R1 reserved bits zero");

    finish_run();
  end

endmodule